// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block holds the sticky interrupt status of a USB host controller. The controller core feeds it single-cycle event pulses and a few levels. These cover scheduling overrun, done-queue writeback, start of frame, resume signalling, a non-USB system error, the top bit of the frame counter with a frame-number-updated strobe, root hub and downstream port changes, and an ownership-change request. The block turns some of these into derived events, for example edges and toggles. It latches each event into its own status bit.

Software reads the 32-bit status word from `status_rd` at all times. It clears bits by writing through a one-cycle write strobe, where a 1 in a bit position clears that bit. Three outputs are built from the status word and a companion enable vector: an interrupt request, a system-management interrupt and a halt. The port list is plain control and status wiring. No stream passes through the block, so no port has a valid/ready handshake or back-pressure.

Each event sets its bit at the rising clock edge that samples it. The new value appears on `status_rd` for the whole of the following cycle. The edge detectors compare the present input against registered copies taken one cycle earlier. Those copies reset to 0.

Top module: `usb_hc_intstat`

## Requirements
- R1: Status bit positions are SO=0, WDH=1, SF=2, RD=3, UE=4, FNO=5, RHSC=6 and OC=30. All other bits of `status_rd` always read 0. Every bit is 0 after reset.
- R2: A write with `wr_en`=1 clears each status bit whose `wr_data` bit is 1. A 0 in `wr_data` leaves the bit as it is. When a set event and a clear hit the same bit in the same cycle, the bit ends up 1.
- R3: A pulse on `sched_ovr_p`, `donewb_p` or `sof_p` sets SO, WDH or SF respectively.
- R4: FNO sets when `frame_msb` differs from its value in the previous cycle, in either direction. FNO also sets on `frame_upd_p`.
- R5: RD sets only in a cycle where `resume_lvl` is 1 after being 0 in the previous cycle. The rise does not set RD when `resume_cmd` is 1 in that same cycle.
- R6: A pulse on `syserr_p` sets UE, and `halt` equals UE. A write of 1 to UE clears it only if `hc_reset_p` has pulsed since UE was last set. Otherwise UE stays at 1.
- R7: RHSC sets on `hub_chg_p` or on a pulse of any bit of `port_chg_p`.
- R8: A pulse on `own_req_p` sets OC. `smi` equals OC AND `int_en[30]`, so it rises in the same cycle that OC first reads 1.
- R9: With `SMI_PRESENT`=0, OC always reads 0 and `smi` stays 0.
- R10: `irq` equals `master_en` AND the OR over bits 0 to 6 of (status AND `int_en`). OC never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_ovr_p | input | 1 | Scheduling overrun pulse |
| donewb_p | input | 1 | Done-queue writeback pulse |
| sof_p | input | 1 | Start-of-frame pulse |
| resume_lvl | input | 1 | Resume signalling seen on the bus (level) |
| resume_cmd | input | 1 | Controller is in the software-commanded resume state |
| syserr_p | input | 1 | Non-USB system error pulse |
| frame_msb | input | 1 | Most significant bit of the frame counter |
| frame_upd_p | input | 1 | Frame number written to memory pulse |
| hub_chg_p | input | 1 | Root hub status change pulse |
| port_chg_p | input | NPORTS | Per-downstream-port status change pulses |
| own_req_p | input | 1 | Ownership-change request pulse |
| hc_reset_p | input | 1 | Controller reset completed pulse |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write-1-to-clear mask |
| int_en | input | 32 | Per-bit interrupt enables |
| master_en | input | 1 | Master interrupt enable for `irq` |
| status_rd | output | 32 | Current status word |
| irq | output | 1 | Interrupt request |
| smi | output | 1 | System-management interrupt |
| halt | output | 1 | Stop processing and signalling |

## Verification
The hardest situation to reach from the ports involves UE. A clear of UE must be refused while it is unarmed and honoured after `hc_reset_p`. The order of error, write and controller reset matters here, and new errors that arrive in between re-arm the lock. A second hard case is a resume rise that happens while the commanded-resume state is held. The random stimulus makes errors and controller resets rare. It toggles the resume level and the command state on their own. Directed sequences then force the error, blocked clear, reset and accepted clear chain. They also force a resume rise under command, a frame MSB toggle both ways, and a set and clear of the same bit in one cycle.

// File: rtl/hcis_pkg.sv
package hcis_pkg;
  localparam int STAT_W = 32;
  localparam int B_SO   = 0;
  localparam int B_WDH  = 1;
  localparam int B_SF   = 2;
  localparam int B_RD   = 3;
  localparam int B_UE   = 4;
  localparam int B_FNO  = 5;
  localparam int B_RHSC = 6;
  localparam int B_OC   = 30;
  localparam logic [STAT_W-1:0] IRQ_MASK  = (STAT_W'(1) << (B_RHSC + 1)) - STAT_W'(1);
  localparam logic [STAT_W-1:0] IMPL_MASK = IRQ_MASK | (STAT_W'(1) << B_OC);
endpackage

// File: rtl/hcis_evt.sv
module hcis_evt
  import hcis_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter bit SMI_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_ovr_p,
  input  logic              donewb_p,
  input  logic              sof_p,
  input  logic              resume_lvl,
  input  logic              resume_cmd,
  input  logic              syserr_p,
  input  logic              frame_msb,
  input  logic              frame_upd_p,
  input  logic              hub_chg_p,
  input  logic [NPORTS-1:0] port_chg_p,
  input  logic              own_req_p,
  output logic [STAT_W-1:0] set_vec
);
  logic msb_q;
  logic res_q;

  // one-cycle-delayed samples for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      msb_q <= frame_msb;
      res_q <= resume_lvl;
    end
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_SO]   = sched_ovr_p;
    set_vec[B_WDH]  = donewb_p;
    set_vec[B_SF]   = sof_p;
    set_vec[B_RD]   = resume_lvl & ~res_q & ~resume_cmd;
    set_vec[B_UE]   = syserr_p;
    set_vec[B_FNO]  = (frame_msb ^ msb_q) | frame_upd_p;
    set_vec[B_RHSC] = hub_chg_p | (|port_chg_p);
    set_vec[B_OC]   = own_req_p & SMI_PRESENT;
  end

  // R5
  rd_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_lvl |-> !set_vec[B_RD]);
endmodule

// File: rtl/hcis_bank.sv
module hcis_bank
  import hcis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              hc_reset_p,
  output logic [STAT_W-1:0] stat
);
  logic              ue_armed;
  logic [STAT_W-1:0] clr;

  always_comb begin
    clr = wr_en ? (wr_data & IMPL_MASK) : '0;
    if (!ue_armed) clr[B_UE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= '0;
      ue_armed <= 1'b0;
    end else begin
      stat <= (set_vec | (stat & ~clr)) & IMPL_MASK;
      if (set_vec[B_UE])  ue_armed <= 1'b0;
      else if (hc_reset_p) ue_armed <= 1'b1;
    end
  end

  // R6
  ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[B_UE] && !ue_armed) |=> stat[B_UE]);

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit_chk
    if (IMPL_MASK[i]) begin : g_impl
      // R2
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> stat[i]);
      if (i != B_UE) begin : g_w1c
        // R2
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && wr_data[i] && !set_vec[i]) |=> !stat[i]);
      end
    end
  end
endmodule

// File: rtl/hcis_out.sv
module hcis_out
  import hcis_pkg::*;
#(
  parameter bit SMI_PRESENT = 1'b1
) (
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] int_en,
  input  logic              master_en,
  output logic              irq,
  output logic              smi,
  output logic              halt
);
  assign irq  = master_en & (|(stat & int_en & IRQ_MASK));
  assign smi  = SMI_PRESENT & stat[B_OC] & int_en[B_OC];
  assign halt = stat[B_UE];
endmodule

// File: rtl/usb_hc_intstat.sv
module usb_hc_intstat
  import hcis_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter bit SMI_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_ovr_p,
  input  logic              donewb_p,
  input  logic              sof_p,
  input  logic              resume_lvl,
  input  logic              resume_cmd,
  input  logic              syserr_p,
  input  logic              frame_msb,
  input  logic              frame_upd_p,
  input  logic              hub_chg_p,
  input  logic [NPORTS-1:0] port_chg_p,
  input  logic              own_req_p,
  input  logic              hc_reset_p,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       int_en,
  input  logic              master_en,
  output logic [31:0]       status_rd,
  output logic              irq,
  output logic              smi,
  output logic              halt
);
  logic [STAT_W-1:0] set_vec;

  hcis_evt #(.NPORTS(NPORTS), .SMI_PRESENT(SMI_PRESENT)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .sched_ovr_p(sched_ovr_p), .donewb_p(donewb_p), .sof_p(sof_p),
    .resume_lvl(resume_lvl), .resume_cmd(resume_cmd), .syserr_p(syserr_p),
    .frame_msb(frame_msb), .frame_upd_p(frame_upd_p),
    .hub_chg_p(hub_chg_p), .port_chg_p(port_chg_p), .own_req_p(own_req_p),
    .set_vec(set_vec)
  );

  hcis_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .wr_en(wr_en), .wr_data(wr_data), .hc_reset_p(hc_reset_p),
    .stat(status_rd)
  );

  hcis_out #(.SMI_PRESENT(SMI_PRESENT)) u_out (
    .stat(status_rd), .int_en(int_en), .master_en(master_en),
    .irq(irq), .smi(smi), .halt(halt)
  );

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd & ~IMPL_MASK) == '0);

  // R5
  rd_cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_cmd && !status_rd[B_RD]) |=> !status_rd[B_RD]);

  // R8
  smi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> (status_rd[B_OC] && int_en[B_OC]));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> master_en);

  if (!SMI_PRESENT) begin : g_no_smi
    // R9
    oc_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_rd[B_OC] && !smi);
  end
endmodule

// File: tb/usb_hc_intstat_bench.sv
module usb_hc_intstat_bench;
  localparam int NP = 4;
  localparam logic [31:0] MASK = 32'h4000_007F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic so_p, wdh_p, sof_p, res_lvl, res_cmd, err_p, msb, upd_p, hub_p, own_p, hcrst_p;
  logic wr_en, master_en;
  logic [NP-1:0] port_p;
  logic [31:0] wr_data, int_en;
  logic [31:0] st_a, st_b;
  logic irq_a, smi_a, halt_a, irq_b, smi_b, halt_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_a = '0, exp_b = '0;
  bit armed = 1'b0, m_msb = 1'b0, m_res = 1'b0;

  always #10 clk = ~clk;

  usb_hc_intstat #(.NPORTS(NP), .SMI_PRESENT(1'b1)) u_usb_hc_intstat (
    .clk(clk), .rst_n(rst_n), .sched_ovr_p(so_p), .donewb_p(wdh_p), .sof_p(sof_p),
    .resume_lvl(res_lvl), .resume_cmd(res_cmd), .syserr_p(err_p), .frame_msb(msb),
    .frame_upd_p(upd_p), .hub_chg_p(hub_p), .port_chg_p(port_p), .own_req_p(own_p),
    .hc_reset_p(hcrst_p), .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
    .master_en(master_en), .status_rd(st_a), .irq(irq_a), .smi(smi_a), .halt(halt_a));

  usb_hc_intstat #(.NPORTS(NP), .SMI_PRESENT(1'b0)) u_nosmi (
    .clk(clk), .rst_n(rst_n), .sched_ovr_p(so_p), .donewb_p(wdh_p), .sof_p(sof_p),
    .resume_lvl(res_lvl), .resume_cmd(res_cmd), .syserr_p(err_p), .frame_msb(msb),
    .frame_upd_p(upd_p), .hub_chg_p(hub_p), .port_chg_p(port_p), .own_req_p(own_p),
    .hc_reset_p(hcrst_p), .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
    .master_en(master_en), .status_rd(st_b), .irq(irq_b), .smi(smi_b), .halt(halt_b));

  function automatic string req_of(input int b);
    case (b)
      0, 1, 2: return "R3";
      3:       return "R5";
      4:       return "R6";
      5:       return "R4";
      6:       return "R7";
      30:      return "R8";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [31:0] set_model(input bit smi_on);
    logic [31:0] s = '0;
    s[0]  = so_p;
    s[1]  = wdh_p;
    s[2]  = sof_p;
    s[3]  = res_lvl && !m_res && !res_cmd;
    s[4]  = err_p;
    s[5]  = (msb != m_msb) || upd_p;
    s[6]  = hub_p || (|port_p);
    s[30] = own_p && smi_on;
    return s;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_status(input string who, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      for (int b = 0; b < 32; b++)
        if (act[b] !== exp[b]) begin
          $display("FAIL %s %s bit%0d actual=%h expected=%h", req_of(b), who, b, act, exp);
          break;
        end
    end
  endtask

  // advance one clock with the present inputs, then compare at the negedge
  task automatic cycle();
    logic [31:0] sa, sb, clr;
    sa  = set_model(1'b1);
    sb  = set_model(1'b0);
    clr = wr_en ? (wr_data & MASK) : '0;
    if (!armed) clr[4] = 1'b0;
    exp_a = (exp_a & ~clr) | sa;
    exp_b = (exp_b & ~clr) | sb;
    if (sa[4]) armed = 1'b0;
    else if (hcrst_p) armed = 1'b1;
    m_msb = msb;
    m_res = res_lvl;
    @(negedge clk);
    chk_status("status", st_a, exp_a);
    chk_status("status_nosmi", st_b, exp_b);
    chk("R10", "irq", {31'd0, irq_a}, {31'd0, master_en && |(exp_a & int_en & 32'h7F)});
    chk("R8", "smi", {31'd0, smi_a}, {31'd0, exp_a[30] && int_en[30]});
    chk("R6", "halt", {31'd0, halt_a}, {31'd0, exp_a[4]});
    chk("R9", "smi_nosmi", {31'd0, smi_b}, 32'd0);
    chk("R10", "irq_nosmi", {31'd0, irq_b}, {31'd0, master_en && |(exp_b & int_en & 32'h7F)});
  endtask

  task automatic idle();
    so_p = 0; wdh_p = 0; sof_p = 0; err_p = 0; upd_p = 0; hub_p = 0; own_p = 0;
    hcrst_p = 0; port_p = '0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    res_lvl = 0; res_cmd = 0; msb = 0; master_en = 1; int_en = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset status", st_a, 32'd0);
    chk("R1", "reset status_nosmi", st_b, 32'd0);
    chk("R10", "reset irq", {31'd0, irq_a}, 32'd0);
    rst_n = 1'b1;
    cycle();

    // R4 frame MSB toggles both ways
    msb = 1; cycle();
    wr_en = 1; wr_data = 32'h20; cycle(); idle();
    msb = 0; cycle();
    wr_en = 1; wr_data = 32'hFFFF_FFFF; cycle(); idle();
    // R5 rise under commanded resume, then a free rise
    res_cmd = 1; res_lvl = 1; cycle();
    res_cmd = 0; cycle();
    res_lvl = 0; cycle();
    res_lvl = 1; cycle();
    // R2 set and clear in the same cycle
    so_p = 1; wr_en = 1; wr_data = 32'hFFFF_FFFF; cycle(); idle();
    // R6 blocked clear, controller reset, accepted clear
    err_p = 1; cycle(); idle();
    wr_en = 1; wr_data = 32'h10; cycle(); idle();
    hcrst_p = 1; cycle(); idle();
    wr_en = 1; wr_data = 32'h10; cycle(); idle();
    // R8 R9 ownership change with SMI enable; R7 port change
    own_p = 1; int_en = 32'h4000_0000; cycle(); idle();
    port_p = 4'b0100; master_en = 0; cycle(); idle();

    for (int n = 0; n < 3000; n++) begin
      idle();
      so_p  = ($urandom % 8) == 0;
      wdh_p = ($urandom % 8) == 0;
      sof_p = ($urandom % 8) == 0;
      upd_p = ($urandom % 12) == 0;
      hub_p = ($urandom % 12) == 0;
      own_p = ($urandom % 16) == 0;
      err_p = ($urandom % 40) == 0;
      hcrst_p = ($urandom % 20) == 0;
      for (int p = 0; p < NP; p++) port_p[p] = ($urandom % 20) == 0;
      if (($urandom % 10) == 0) msb = ~msb;
      if (($urandom % 6) == 0) res_lvl = ~res_lvl;
      if (($urandom % 5) == 0) res_cmd = ~res_cmd;
      if (($urandom % 4) == 0) begin
        wr_en = 1; wr_data = $urandom;
      end
      if (($urandom % 50) == 0) begin
        int_en = $urandom; master_en = $urandom % 2;
      end
      cycle();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule